// File: doc/BRIEF.md
# Wakeup Event Router

The router gathers single-bit event lines from peripherals into one registered wake request. There are eighteen sources: wakeup pins, timers, bus controllers, brown-out, watchdog and reset. Each source has its own detector. A mode bit chooses edge or level detection, and a polarity bit chooses which edge or which level counts. A detected event sets a sticky status bit. An enable mask selects which status bits can drive the request.

Software reaches the block over a small synchronous register bus with word addresses. The polarity and mode registers can be read and written. The enable and status registers are read-only. They change only through four write-only registers that set or clear bits when a 1 is written. Status bits come out of reset set, so software must clear them before it arms the router. The event inputs are assumed to be already synchronous to `clk`.

Top module: `wake_event_router`

## Requirements
- R1: After reset, polarity, mode and enable read as 0. Status reads 0x0009FFFF, with every implemented bit set. wake_req is 0.
- R2: Only bit positions 0 to 16 and 19 are implemented. All other bit positions read as 0 in every register. The polarity register (word 0) and the mode register (word 1) can be read and written.
- R3: A write to word 3 sets each enable bit (read at word 2) whose data bit is 1. Enable bits under a 0 data bit are unchanged.
- R4: A write to word 4 clears each enable bit whose data bit is 1. Enable bits under a 0 data bit are unchanged.
- R5: Status is read at word 5. A write to word 6 sets the status bits under 1s in the data. A write to word 7 clears them. Bits under 0s are unchanged.
- R6: With mode bit 1 (edge), polarity 1 sets status on a rising edge and polarity 0 on a falling edge. The opposite edge does not set status.
- R7: With mode bit 0 (level), polarity 1 sets status while the input is high and polarity 0 while it is low. A clear has no lasting effect while the active level is present. Once the level goes inactive, a clear takes effect.
- R8: When a detection and a status clear hit the same bit in the same cycle, the bit stays set.
- R9: wake_req is the OR of status AND enable over the implemented bits, registered. It changes one cycle after the status or enable change that causes it.
- R10: Reads of words 3, 4, 6, 7 and of undecoded words 8 to 15 return 0. Writes to words 2 and 5 change nothing.
- R11: Event inputs at unimplemented bit positions never set any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | 32 | Event lines, synchronous to clk, one per bit position |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wake_req | output | 1 | Registered combined wake request |

## Verification
The properties assume that ev_in is already synchronous to clk and stable around the sampling edge. They also assume that at most one register access occurs per cycle, so a set and a clear of the same register never coincide.

The bench drives events and bus accesses only on the falling edge and holds each for a whole cycle. It settles the event lines to the inactive level before it changes the mode or polarity. Status is cleared after each configuration change, so the properties only see detections that the stimulus intends.

// File: rtl/wer_pkg.sv
package wer_pkg;

  // Word addresses of the register bus.
  localparam int ADR_POL      = 0;
  localparam int ADR_MODE     = 1;
  localparam int ADR_ENA      = 2;
  localparam int ADR_ENA_SET  = 3;
  localparam int ADR_ENA_CLR  = 4;
  localparam int ADR_STAT     = 5;
  localparam int ADR_STAT_SET = 6;
  localparam int ADR_STAT_CLR = 7;

  // Detection for one source.
  // Edge mode: cur differs from prev and now equals pol.
  // Level mode: cur equals pol.
  function automatic logic src_hit(input logic edge_mode, input logic pol,
                                   input logic cur, input logic prev,
                                   input logic armed);
    if (edge_mode) return armed & (cur ^ prev) & ~(cur ^ pol);
    else           return ~(cur ^ pol);
  endfunction

  // Next value of a sticky bit. Hardware hit and software set both beat clear.
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr, input logic hit);
    return (cur & ~clr) | set | hit;
  endfunction

endpackage

// File: rtl/wer_cfg_reg.sv
module wer_cfg_reg #(
  parameter int                  DATA_W   = 32,
  parameter logic [DATA_W-1:0]   SRC_MASK = 32'h0009_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & SRC_MASK;
  end

endmodule

// File: rtl/wer_detect.sv
module wer_detect #(
  parameter int                  DATA_W   = 32,
  parameter logic [DATA_W-1:0]   SRC_MASK = 32'h0009_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ev_in,
  input  logic [DATA_W-1:0] edge_sel,
  input  logic [DATA_W-1:0] pol_sel,
  output logic [DATA_W-1:0] hits
);

  // Edge detection is held off until one input sample has been captured.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (SRC_MASK[i]) begin : g_src
      logic prev;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= ev_in[i];
      end
      assign hits[i] = wer_pkg::src_hit(edge_sel[i], pol_sel[i], ev_in[i],
                                        prev, armed);
    end else begin : g_none
      assign hits[i] = 1'b0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{ev_in & ~SRC_MASK, edge_sel & ~SRC_MASK,
                         pol_sel & ~SRC_MASK};

endmodule

// File: rtl/wer_sticky.sv
module wer_sticky #(
  parameter int                  DATA_W   = 32,
  parameter logic [DATA_W-1:0]   SRC_MASK = 32'h0009_FFFF,
  parameter logic [DATA_W-1:0]   RST_VAL  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] set_v,
  input  logic [DATA_W-1:0] clr_v,
  input  logic [DATA_W-1:0] hit_v,
  output logic [DATA_W-1:0] q
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (SRC_MASK[i]) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= RST_VAL[i];
        else        q[i] <= wer_pkg::sticky_next(q[i], set_v[i], clr_v[i], hit_v[i]);
      end
    end else begin : g_none
      assign q[i] = 1'b0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{set_v & ~SRC_MASK, clr_v & ~SRC_MASK, hit_v & ~SRC_MASK};

endmodule

// File: rtl/wake_event_router.sv
module wake_event_router #(
  parameter int                  DATA_W   = 32,
  parameter int                  ADDR_W   = 4,
  parameter logic [DATA_W-1:0]   SRC_MASK = 32'h0009_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ev_in,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wake_req
);
  import wer_pkg::*;

  // Write strobes, one per writable word.
  logic wr_any, wr_pol, wr_mode, wr_ena_set, wr_ena_clr, wr_stat_set, wr_stat_clr;
  assign wr_any      = bus_sel & bus_we;
  assign wr_pol      = wr_any & (bus_addr == ADDR_W'(ADR_POL));
  assign wr_mode     = wr_any & (bus_addr == ADDR_W'(ADR_MODE));
  assign wr_ena_set  = wr_any & (bus_addr == ADDR_W'(ADR_ENA_SET));
  assign wr_ena_clr  = wr_any & (bus_addr == ADDR_W'(ADR_ENA_CLR));
  assign wr_stat_set = wr_any & (bus_addr == ADDR_W'(ADR_STAT_SET));
  assign wr_stat_clr = wr_any & (bus_addr == ADDR_W'(ADR_STAT_CLR));

  logic [DATA_W-1:0] pol_q, mode_q, ena_q, stat_q, hits;
  logic [DATA_W-1:0] ena_set_v, ena_clr_v, stat_set_v, stat_clr_v;
  assign ena_set_v  = wr_ena_set  ? bus_wdata : '0;
  assign ena_clr_v  = wr_ena_clr  ? bus_wdata : '0;
  assign stat_set_v = wr_stat_set ? bus_wdata : '0;
  assign stat_clr_v = wr_stat_clr ? bus_wdata : '0;

  wer_cfg_reg #(.DATA_W(DATA_W), .SRC_MASK(SRC_MASK)) u_pol (
    .clk(clk), .rst_n(rst_n), .we(wr_pol), .wdata(bus_wdata), .q(pol_q));

  wer_cfg_reg #(.DATA_W(DATA_W), .SRC_MASK(SRC_MASK)) u_mode (
    .clk(clk), .rst_n(rst_n), .we(wr_mode), .wdata(bus_wdata), .q(mode_q));

  wer_detect #(.DATA_W(DATA_W), .SRC_MASK(SRC_MASK)) u_detect (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .edge_sel(mode_q),
    .pol_sel(pol_q), .hits(hits));

  wer_sticky #(.DATA_W(DATA_W), .SRC_MASK(SRC_MASK), .RST_VAL('0)) u_ena (
    .clk(clk), .rst_n(rst_n), .set_v(ena_set_v), .clr_v(ena_clr_v),
    .hit_v('0), .q(ena_q));

  wer_sticky #(.DATA_W(DATA_W), .SRC_MASK(SRC_MASK), .RST_VAL(SRC_MASK)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_v(stat_set_v), .clr_v(stat_clr_v),
    .hit_v(hits), .q(stat_q));

  // Combined request, one register stage.
  logic wake_any;
  assign wake_any = |(stat_q & ena_q);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_req <= 1'b0;
    else        wake_req <= wake_any;
  end

  // Read mux. Write-only and undecoded words return zero.
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_POL))  bus_rdata = pol_q;
    if (bus_addr == ADDR_W'(ADR_MODE)) bus_rdata = mode_q;
    if (bus_addr == ADDR_W'(ADR_ENA))  bus_rdata = ena_q;
    if (bus_addr == ADDR_W'(ADR_STAT)) bus_rdata = stat_q;
  end

endmodule

// File: rtl/wer_checker.sv
module wer_checker #(
  parameter int                  DATA_W   = 32,
  parameter int                  ADDR_W   = 4,
  parameter logic [DATA_W-1:0]   SRC_MASK = 32'h0009_FFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] hits,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] ena_q,
  input logic              wake_req
);
  import wer_pkg::*;

  logic w_ena_set, w_ena_clr, w_stat_clr, rd_wo;
  assign w_ena_set  = bus_sel && bus_we && bus_addr == ADDR_W'(ADR_ENA_SET);
  assign w_ena_clr  = bus_sel && bus_we && bus_addr == ADDR_W'(ADR_ENA_CLR);
  assign w_stat_clr = bus_sel && bus_we && bus_addr == ADDR_W'(ADR_STAT_CLR);
  assign rd_wo = bus_addr == ADDR_W'(ADR_ENA_SET) || bus_addr == ADDR_W'(ADR_ENA_CLR) ||
                 bus_addr == ADDR_W'(ADR_STAT_SET) || bus_addr == ADDR_W'(ADR_STAT_CLR);

  // R2: unimplemented positions never read as 1
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~SRC_MASK) == '0);

  // R3
  a_r3_ena_set: assert property (@(posedge clk) disable iff (!rst_n)
    w_ena_set |=> ((ena_q & $past(bus_wdata & SRC_MASK)) == $past(bus_wdata & SRC_MASK)));

  // R4
  a_r4_ena_clr: assert property (@(posedge clk) disable iff (!rst_n)
    w_ena_clr |=> ((ena_q & $past(bus_wdata)) == '0));

  // R5: clear takes effect where no detection competes
  a_r5_stat_clr: assert property (@(posedge clk) disable iff (!rst_n)
    w_stat_clr |=> ((stat_q & $past(bus_wdata & ~hits)) == '0));

  // R8: a detection always leaves its status bit set
  a_r8_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hits) |=> ((stat_q & $past(hits)) == $past(hits)));

  // R9
  a_r9_wake_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & ena_q)) |=> wake_req);
  a_r9_wake_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_q & ena_q)) |=> !wake_req);

  // R10
  a_r10_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wo |-> bus_rdata == '0);

endmodule

bind wake_event_router wer_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_MASK(SRC_MASK)
) u_wer_checker (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .hits(hits), .stat_q(stat_q), .ena_q(ena_q), .wake_req(wake_req)
);

// File: tb/test_wake_event_router.sv
`timescale 1ns/1ps
module test_wake_event_router;
  localparam logic [31:0] M = 32'h0009_FFFF;
  localparam logic [3:0] A_POL = 0, A_MODE = 1, A_ENA = 2, A_ESET = 3, A_ECLR = 4,
                         A_STAT = 5, A_SSET = 6, A_SCLR = 7;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] ev_in = '1;
  logic        bus_sel = 0, bus_we = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wake_req;

  wake_event_router i_wake_event_router (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_req(wake_req));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #0.5;
    chk(tag, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);

    // R1 reset state
    rd_chk("R1 pol", A_POL, 0);
    rd_chk("R1 mode", A_MODE, 0);
    rd_chk("R1 ena", A_ENA, 0);
    rd_chk("R1 stat", A_STAT, M);
    chk("R1 wake", {31'b0, wake_req}, 0);

    // R2 config read/write, unused bits zero
    wr(A_POL, '1);  rd_chk("R2 pol ones", A_POL, M);
    wr(A_MODE, '1); rd_chk("R2 mode ones", A_MODE, M);
    wr(A_POL, 32'h0000_1234); rd_chk("R2 pol pattern", A_POL, 32'h0000_1234);
    wr(A_POL, 0); wr(A_MODE, 0);
    rd_chk("R2 mode back", A_MODE, 0);

    // R10 read-only words ignore writes, write-only words read zero
    wr(A_ENA, '1);  rd_chk("R10 ena unchanged", A_ENA, 0);
    wr(A_STAT, 0);  rd_chk("R10 stat unchanged", A_STAT, M);
    wr(A_ESET, 32'h3);
    for (int a = 3; a < 16; a++)
      if (a != 5) rd_chk("R10 read zero", 4'(a), 0);
    wr(A_ECLR, '1);

    // Detection sweep over all four mode/polarity combinations
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 2; p++) begin
        logic [31:0] idle;
        string tg;
        idle = p ? 32'h0 : 32'hFFFF_FFFF;
        tg = m ? "R6" : "R7";
        ev_in = idle;
        tick(2);
        wr(A_MODE, m ? M : 0);
        wr(A_POL, p ? M : 0);
        tick(2);
        wr(A_SCLR, '1);
        rd_chk({tg, " cleared"}, A_STAT, 0);
        // R11 unused positions driven active
        ev_in = idle ^ ~M;
        tick(1);
        rd_chk("R11 unused inputs", A_STAT, 0);
        ev_in = idle;
        tick(1);
        rd_chk("R11 unused inputs back", A_STAT, 0);
        for (int i = 0; i < 32; i++)
          if (M[i]) begin
            ev_in[i] = p[0];
            tick(1);
            rd_chk({tg, " detect"}, A_STAT, 32'h1 << i);
            if (m == 0) begin
              wr(A_SCLR, 32'h1 << i);
              rd_chk("R7 clear while active", A_STAT, 32'h1 << i);
            end
            ev_in[i] = ~p[0];
            tick(1);
            rd_chk({tg, " latched after release"}, A_STAT, 32'h1 << i);
            wr(A_SCLR, 32'h1 << i);
            rd_chk("R5 clear", A_STAT, 0);
          end
      end

    // Now in edge mode, rising polarity, inputs idle low.
    // R3 / R4 enable set and clear
    wr(A_ESET, 32'h5);  rd_chk("R3 set", A_ENA, 32'h5);
    wr(A_ESET, 0);      rd_chk("R3 zero write", A_ENA, 32'h5);
    wr(A_ECLR, 0);      rd_chk("R4 zero write", A_ENA, 32'h5);

    // R9 latency
    wr(A_SSET, 32'h4);
    chk("R9 not yet", {31'b0, wake_req}, 0);
    tick(1);
    chk("R9 raised", {31'b0, wake_req}, 1);
    wr(A_ECLR, 32'h4);
    rd_chk("R4 clear", A_ENA, 32'h1);
    chk("R9 still high", {31'b0, wake_req}, 1);
    tick(1);
    chk("R9 dropped", {31'b0, wake_req}, 0);
    wr(A_ESET, '1);  rd_chk("R3 all", A_ENA, M);
    wr(A_ECLR, '1);  rd_chk("R4 all", A_ENA, 0);

    // R9 per-source sweep
    for (int i = 0; i < 32; i++)
      if (M[i]) begin
        wr(A_SCLR, '1);
        wr(A_SSET, 32'h1 << i);
        wr(A_ESET, M & ~(32'h1 << i));
        tick(2);
        chk("R9 other enables", {31'b0, wake_req}, 0);
        wr(A_ESET, 32'h1 << i);
        tick(1);
        chk("R9 own enable", {31'b0, wake_req}, 1);
        wr(A_ECLR, '1);
        tick(1);
        chk("R9 disabled", {31'b0, wake_req}, 0);
      end

    // R5 set-status semantics
    wr(A_SCLR, '1);
    wr(A_SSET, 0);   rd_chk("R5 zero set", A_STAT, 0);
    wr(A_SSET, '1);  rd_chk("R5 set all", A_STAT, M);
    wr(A_SCLR, '1);

    // R8 detection and clear in the same cycle
    wr(A_SSET, 32'h8);
    bus_sel = 1; bus_we = 1; bus_addr = A_SCLR; bus_wdata = 32'h8;
    ev_in[3] = 1'b1;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_wdata = '0;
    rd_chk("R8 detection wins", A_STAT, 32'h8);
    ev_in[3] = 1'b0;
    tick(1);
    wr(A_SCLR, 32'h8);
    rd_chk("R8 clear alone", A_STAT, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule